// File: doc/BRIEF.md
# Register Rename with Speculative and Committed Maps

This block maps architectural register numbers onto physical register tags for an out-of-order core. It handles one instruction per cycle at decode. For each instruction it returns the physical tags of the two source operands, a freshly allocated tag for the destination, and the tag that destination held before. The defaults are 32 architectural registers and 64 physical tags. Tags are 6-bit numbers from 0 to 63, and physical tag k is the register numbered P(k+1).

There are two maps. The speculative map follows every renamed instruction. The committed map follows only retired instructions. At retire, the tag that the committed map held for the retiring destination goes back to the pool of free tags. A flush copies the committed map into the speculative map and rebuilds the pool from the committed map, which throws away all wrong-path allocations in one cycle. The rename outputs are combinational from the current state. All state changes on the rising clock edge.

Top module: `reg_rename`

## Requirements
- R1: After reset, both maps send architectural register r to tag r. The free pool holds tags 32 to 63, so the first renamed destination gets tag 32.
- R2: An accepted destination always gets the lowest-numbered free tag. From a fresh start this gives 32, 33, 34 and so on. A tag that has been allocated is no longer free.
- R3: Source tags are read from the speculative map. A later instruction sees the newest tag given to an earlier destination. When an instruction's source is also its own destination, the source returns the mapping from before this instruction.
- R4: `ren_old_tag_o` equals the speculative mapping of `ren_dst_i` before this instruction. An accepted rename writes the new tag into the speculative map on the clock edge.
- R5: The committed map changes only on a retire (`ret_valid_i` = 1). Renames never change it.
- R6: An instruction with `ren_dst_we_i` = 0 allocates no tag and leaves both maps unchanged.
- R7: On a retire, the tag that the committed map held for `ret_dst_i` returns to the free pool, and the committed entry becomes `ret_tag_i`.
- R8: When `flush_i` = 1, the speculative map takes the committed map on the next edge, including a retire in the same cycle. The free pool becomes every tag not named in that map, and a rename in the flush cycle is dropped.
- R9: `ren_ready_o` is 0 exactly when `ren_dst_we_i` = 1 and no tag is free. A stalled instruction changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ren_valid_i | input | 1 | Instruction present at rename |
| ren_src_a_i | input | 5 | First source architectural register |
| ren_src_b_i | input | 5 | Second source architectural register |
| ren_dst_i | input | 5 | Destination architectural register |
| ren_dst_we_i | input | 1 | Instruction writes a destination |
| ren_ready_o | output | 1 | Rename can accept this instruction |
| ren_src_a_tag_o | output | 6 | Physical tag of first source |
| ren_src_b_tag_o | output | 6 | Physical tag of second source |
| ren_dst_tag_o | output | 6 | Newly allocated destination tag |
| ren_old_tag_o | output | 6 | Previous speculative tag of the destination |
| ret_valid_i | input | 1 | Instruction retires this cycle |
| ret_dst_i | input | 5 | Retiring destination architectural register |
| ret_tag_i | input | 6 | Tag that becomes committed for it |
| flush_i | input | 1 | Restore speculative state from committed state |

## Verification
Some properties are checked by assertions on every cycle:
- the committed map holds still when nothing retires;
- a no-destination instruction leaves the speculative map alone;
- an allocated tag leaves the pool;
- a flush makes the speculative map equal to the committed map;
- a flush leaves exactly 32 free tags;
- a stall occurs only with an empty pool.

Other behaviours only the bench scenarios can show:
- the lowest-first allocation order;
- a source seeing the old mapping in the same cycle and the new mapping one cycle later;
- a retired tag being handed out again;
- wrong-path renames disappearing after a flush.

The bench compares these against a behavioural model on every step.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int unsigned DEF_ARCH = 32;
  localparam int unsigned DEF_PHYS = 64;

  typedef enum logic [1:0] {
    FL_HOLD    = 2'd0,
    FL_UPDATE  = 2'd1,
    FL_REBUILD = 2'd2
  } fl_op_e;
endpackage

// File: rtl/rr_map_table.sv
module rr_map_table #(
  parameter int unsigned NUM_ARCH = rr_pkg::DEF_ARCH,
  parameter int unsigned NUM_PHYS = rr_pkg::DEF_PHYS,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned TW = $clog2(NUM_PHYS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [AW-1:0]          rd_a_i,
  input  logic [AW-1:0]          rd_b_i,
  input  logic [AW-1:0]          rd_d_i,
  input  logic                   wr_en_i,
  input  logic [TW-1:0]          wr_tag_i,
  input  logic                   load_i,
  input  logic [NUM_ARCH*TW-1:0] load_map_i,
  output logic [TW-1:0]          rd_a_tag_o,
  output logic [TW-1:0]          rd_b_tag_o,
  output logic [TW-1:0]          rd_d_tag_o,
  output logic [NUM_ARCH*TW-1:0] map_o
);
  logic [TW-1:0] map_q [NUM_ARCH];

  for (genvar g = 0; g < NUM_ARCH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  map_q[g] <= TW'(g);
      else if (load_i)                              map_q[g] <= load_map_i[g*TW +: TW];
      else if (wr_en_i && rd_d_i == AW'(g))         map_q[g] <= wr_tag_i;
    end
    assign map_o[g*TW +: TW] = map_q[g];
  end

  // reads see pre-update state: own sources get the old mapping
  assign rd_a_tag_o = map_q[rd_a_i];
  assign rd_b_tag_o = map_q[rd_b_i];
  assign rd_d_tag_o = map_q[rd_d_i];

  p_flush_copy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> map_o == $past(load_map_i));
  p_write_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !load_i |=> map_q[$past(rd_d_i)] == $past(wr_tag_i));
endmodule

// File: rtl/rr_commit_map.sv
module rr_commit_map #(
  parameter int unsigned NUM_ARCH = rr_pkg::DEF_ARCH,
  parameter int unsigned NUM_PHYS = rr_pkg::DEF_PHYS,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned TW = $clog2(NUM_PHYS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ret_en_i,
  input  logic [AW-1:0]          ret_arch_i,
  input  logic [TW-1:0]          ret_tag_i,
  output logic [TW-1:0]          free_tag_o,
  output logic [NUM_ARCH*TW-1:0] map_next_o,
  output logic [NUM_PHYS-1:0]    used_next_o
);
  logic [TW-1:0] map_q [NUM_ARCH];
  logic [NUM_ARCH*TW-1:0] map_flat;

  for (genvar g = 0; g < NUM_ARCH; g++) begin : g_ent
    logic hit;
    assign hit = ret_en_i && ret_arch_i == AW'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  map_q[g] <= TW'(g);
      else if (hit) map_q[g] <= ret_tag_i;
    end
    assign map_flat[g*TW +: TW]   = map_q[g];
    assign map_next_o[g*TW +: TW] = hit ? ret_tag_i : map_q[g];
  end

  assign free_tag_o = map_q[ret_arch_i];

  always_comb begin
    used_next_o = '0;
    for (int i = 0; i < NUM_ARCH; i++) used_next_o[map_next_o[i*TW +: TW]] = 1'b1;
  end

  p_commit_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ret_en_i |=> $stable(map_flat));
  p_commit_update_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_en_i |=> map_q[$past(ret_arch_i)] == $past(ret_tag_i));
endmodule

// File: rtl/rr_free_list.sv
module rr_free_list #(
  parameter int unsigned NUM_ARCH = rr_pkg::DEF_ARCH,
  parameter int unsigned NUM_PHYS = rr_pkg::DEF_PHYS,
  localparam int unsigned TW = $clog2(NUM_PHYS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  rr_pkg::fl_op_e      op_i,
  input  logic                alloc_i,
  input  logic                ret_i,
  input  logic [TW-1:0]       ret_tag_i,
  input  logic [NUM_PHYS-1:0] used_i,
  output logic                any_free_o,
  output logic [TW-1:0]       pick_tag_o,
  output logic [NUM_PHYS-1:0] free_o
);
  import rr_pkg::*;
  logic [NUM_PHYS-1:0] free_q, free_d, alloc_oh, ret_oh;

  // lowest free tag first
  always_comb begin
    pick_tag_o = '0;
    for (int i = NUM_PHYS - 1; i >= 0; i--) if (free_q[i]) pick_tag_o = TW'(i);
  end
  assign any_free_o = |free_q;

  always_comb begin
    alloc_oh = '0;
    ret_oh   = '0;
    if (alloc_i) alloc_oh[pick_tag_o] = 1'b1;
    if (ret_i)   ret_oh[ret_tag_i]    = 1'b1;
    unique case (op_i)
      FL_REBUILD: free_d = ~used_i;
      FL_UPDATE:  free_d = (free_q & ~alloc_oh) | ret_oh;
      default:    free_d = free_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PHYS; i++) free_q[i] <= (i >= NUM_ARCH);
    end else begin
      free_q <= free_d;
    end
  end
  assign free_o = free_q;

  p_rebuild_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == FL_REBUILD |=> $countones(free_q) == NUM_PHYS - NUM_ARCH);
  p_ret_back_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == FL_UPDATE && ret_i |=> free_q[$past(ret_tag_i)]);
endmodule

// File: rtl/reg_rename.sv
module reg_rename #(
  parameter int unsigned NUM_ARCH = rr_pkg::DEF_ARCH,
  parameter int unsigned NUM_PHYS = rr_pkg::DEF_PHYS,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned TW = $clog2(NUM_PHYS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ren_valid_i,
  input  logic [AW-1:0] ren_src_a_i,
  input  logic [AW-1:0] ren_src_b_i,
  input  logic [AW-1:0] ren_dst_i,
  input  logic          ren_dst_we_i,
  output logic          ren_ready_o,
  output logic [TW-1:0] ren_src_a_tag_o,
  output logic [TW-1:0] ren_src_b_tag_o,
  output logic [TW-1:0] ren_dst_tag_o,
  output logic [TW-1:0] ren_old_tag_o,
  input  logic          ret_valid_i,
  input  logic [AW-1:0] ret_dst_i,
  input  logic [TW-1:0] ret_tag_i,
  input  logic          flush_i
);
  import rr_pkg::*;

  logic                   any_free, alloc_fire;
  logic [TW-1:0]          pick_tag, cmt_free_tag;
  logic [NUM_ARCH*TW-1:0] cmt_next, spec_map;
  logic [NUM_PHYS-1:0]    used_next, free_vec;
  fl_op_e                 fl_op;

  assign ren_ready_o   = !(ren_dst_we_i && !any_free);
  assign alloc_fire    = ren_valid_i && ren_dst_we_i && any_free && !flush_i;
  assign ren_dst_tag_o = pick_tag;
  assign fl_op         = flush_i ? FL_REBUILD :
                         (alloc_fire || ret_valid_i) ? FL_UPDATE : FL_HOLD;

  rr_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_spec (
    .clk_i, .rst_ni,
    .rd_a_i(ren_src_a_i), .rd_b_i(ren_src_b_i), .rd_d_i(ren_dst_i),
    .wr_en_i(alloc_fire), .wr_tag_i(pick_tag),
    .load_i(flush_i), .load_map_i(cmt_next),
    .rd_a_tag_o(ren_src_a_tag_o), .rd_b_tag_o(ren_src_b_tag_o),
    .rd_d_tag_o(ren_old_tag_o), .map_o(spec_map)
  );

  rr_commit_map #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_cmt (
    .clk_i, .rst_ni,
    .ret_en_i(ret_valid_i), .ret_arch_i(ret_dst_i), .ret_tag_i(ret_tag_i),
    .free_tag_o(cmt_free_tag), .map_next_o(cmt_next), .used_next_o(used_next)
  );

  rr_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_free (
    .clk_i, .rst_ni, .op_i(fl_op),
    .alloc_i(alloc_fire), .ret_i(ret_valid_i), .ret_tag_i(cmt_free_tag),
    .used_i(used_next),
    .any_free_o(any_free), .pick_tag_o(pick_tag), .free_o(free_vec)
  );

  p_alloc_taken_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_fire |=> !free_vec[$past(pick_tag)]);
  p_nodst_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ren_dst_we_i && !flush_i |=> $stable(spec_map));
  p_stall_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ren_ready_o |-> $countones(free_vec) == 0);
  p_stall_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ren_ready_o && !flush_i |=> $stable(spec_map));
endmodule

// File: tb/sim_reg_rename.sv
`timescale 1ns/1ps
module sim_reg_rename;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic v, we, rv, fl, rdy;
  logic [4:0] sa, sb, d, rd;
  logic [5:0] rt, ta, tb, td, told;

  reg_rename u0 (
    .clk_i(clk), .rst_ni(rst_n), .ren_valid_i(v), .ren_src_a_i(sa), .ren_src_b_i(sb),
    .ren_dst_i(d), .ren_dst_we_i(we), .ren_ready_o(rdy), .ren_src_a_tag_o(ta),
    .ren_src_b_tag_o(tb), .ren_dst_tag_o(td), .ren_old_tag_o(told),
    .ret_valid_i(rv), .ret_dst_i(rd), .ret_tag_i(rt), .flush_i(fl)
  );

  int spec_m [32];
  int cmt_m [32];
  bit free_m [64];
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  int last_dst, last_old, last_a, last_b;
  bit last_rdy;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lowest();
    for (int i = 0; i < 64; i++) if (free_m[i]) return i;
    return -1;
  endfunction

  task automatic step(bit iv, int ia, int ib, int id, bit iwe,
                      bit irv, int ird, int irt, bit ifl);
    int t;
    bit er, acc;
    @(negedge clk);
    v = iv; sa = 5'(ia); sb = 5'(ib); d = 5'(id); we = iwe;
    rv = irv; rd = 5'(ird); rt = 6'(irt); fl = ifl;
    #1;
    t  = lowest();
    er = !(iwe && t < 0);
    chk(rdy == er, "R9 ready", int'(rdy), int'(er));
    if (iv) begin
      chk(int'(ta) == spec_m[ia], "R3 src a", int'(ta), spec_m[ia]);
      chk(int'(tb) == spec_m[ib], "R3 src b", int'(tb), spec_m[ib]);
      chk(int'(told) == spec_m[id], "R4 old tag", int'(told), spec_m[id]);
      if (iwe && er) chk(int'(td) == t, "R2 lowest free", int'(td), t);
    end
    last_dst = int'(td); last_old = int'(told); last_rdy = rdy;
    last_a = int'(ta); last_b = int'(tb);
    @(posedge clk);
    acc = iv && iwe && (t >= 0) && !ifl;
    if (irv) begin
      free_m[cmt_m[ird]] = 1;
      cmt_m[ird] = irt;
    end
    if (acc) begin
      free_m[t] = 0;
      spec_m[id] = t;
    end
    if (ifl) begin
      for (int i = 0; i < 64; i++) free_m[i] = 1;
      for (int r = 0; r < 32; r++) begin
        spec_m[r] = cmt_m[r];
        free_m[cmt_m[r]] = 0;
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end

  initial begin
    int t0;
    v = 0; we = 0; rv = 0; fl = 0; sa = 0; sb = 0; d = 0; rd = 0; rt = 0;
    for (int r = 0; r < 32; r++) begin spec_m[r] = r; cmt_m[r] = r; end
    for (int i = 0; i < 64; i++) free_m[i] = (i >= 32);
    repeat (3) @(posedge clk);
    rst_n = 1;

    // R1: identity mapping after reset
    for (int r = 0; r < 32; r++) begin
      step(1, r, 31 - r, r, 0, 0, 0, 0, 0);
      chk(last_a == r, "R1 reset map", last_a, r);
    end
    // R1/R2: first allocations 32, 33
    step(1, 2, 3, 1, 1, 0, 0, 0, 0);
    chk(last_dst == 32, "R1 first tag", last_dst, 32);
    chk(last_old == 1, "R4 old of r1", last_old, 1);
    // R3: next sees newest; own source sees old mapping
    step(1, 1, 1, 1, 1, 0, 0, 0, 0);
    chk(last_a == 32 && last_dst == 33, "R3 own src old", last_a, 32);
    step(1, 1, 4, 5, 1, 0, 0, 0, 0);
    chk(last_a == 33, "R3 newest", last_a, 33);
    // R6: branch allocates nothing, maps unchanged
    step(1, 1, 5, 1, 0, 0, 0, 0, 0);
    step(1, 1, 5, 6, 1, 0, 0, 0, 0);
    chk(last_dst == 35 && last_a == 33, "R6 no alloc", last_dst, 35);
    // R7: retire r1 -> 32 frees tag 1, reused first
    step(0, 0, 0, 0, 0, 1, 1, 32, 0);
    step(1, 0, 0, 7, 1, 0, 0, 0, 0);
    chk(last_dst == 1, "R7 freed reuse", last_dst, 1);
    // R5/R8: flush restores committed map; wrong-path tags freed
    step(1, 0, 0, 9, 1, 0, 0, 0, 1);
    step(1, 1, 5, 7, 0, 0, 0, 0, 0);
    chk(last_a == 32, "R8 r1 committed", last_a, 32);
    chk(last_b == 5, "R5 r5 unchanged", last_b, 5);
    step(1, 6, 7, 9, 1, 0, 0, 0, 0);
    chk(last_a == 6 && last_dst == 1, "R8 rebuilt pool", last_dst, 1);
    // R9: exhaust the pool
    t0 = 0;
    for (int k = 0; k < 40; k++) begin
      step(1, k % 32, (k + 3) % 32, (k + 10) % 32, 1, 0, 0, 0, 0);
      if (last_rdy) t0++;
    end
    chk(t0 == 31, "R9 alloc count", t0, 31);
    step(1, 2, 3, 4, 0, 0, 0, 0, 0);
    chk(last_rdy == 1, "R9 no dst ready", int'(last_rdy), 1);
    // R7 while empty: retire frees tag, next rename takes it
    step(1, 2, 3, 4, 1, 1, 2, spec_m[2], 0);
    chk(last_rdy == 0, "R9 stall", int'(last_rdy), 0);
    step(1, 2, 3, 4, 1, 0, 0, 0, 0);
    chk(last_rdy == 1 && last_dst == 2, "R7 freed tag", last_dst, 2);
    // R8: retire and flush together
    step(1, 0, 0, 3, 1, 1, 3, spec_m[3], 1);
    for (int r = 0; r < 32; r++) step(1, r, r, r, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule